// File: doc/BRIEF.md
# Auxiliary-Channel Transaction Retry Sequencer

This block carries one host request over a display auxiliary channel and repeats the exchange until the reply is final. The host drives a command, an address, a byte length and write data, then pulses `start`. The sequencer holds those fields toward a request/reply engine. Before every attempt it clears the engine's done flag with a handshake. It then fires the attempt and waits for the engine to report done, or for a polling watchdog to run out.

Each reply falls into one of five outcomes: accepted, refused, deferred, timed out, or lost because the hot-plug line was low. A deferral and a timeout each draw on their own retry allowance. When an allowance is used up, the transaction ends with a matching failure code. An accepted reply returns the engine's read data. A programmable pause can be placed between a deferral and the next attempt, so that a slow sink gets time to recover.

Top module: `aux_retry_seq`

## Requirements
- R1: A `start` seen while idle latches `req_cmd`, `req_addr`, `req_len` and `req_wdata`. Those values stay on `eng_cmd`, `eng_addr`, `eng_len` and `eng_wdata` for every attempt of that transaction.
- R2: `eng_done_ack` is driven high before each attempt. `eng_launch` pulses for one cycle only on the cycle after `eng_done_ack` was high while `eng_done` was low.
- R3: After a launch, if `eng_done` stays low for WD_CYCLES (default 64) cycles, the attempt counts as a timeout.
- R4: A timeout (reply code 3, or watchdog expiry) is retried at most TO_RETRIES (default 2) times. The next timeout ends the transaction with status 3.
- R5: A deferral (reply code 2) is retried at most DEFER_RETRIES (default 6) times. The next deferral ends the transaction with status 2.
- R6: The timeout and deferral allowances are counted separately, and both start full at each new transaction.
- R7: An accepted reply (code 0) ends with status 0. In the same cycle `rd_valid` pulses, and `rd_data` holds the `eng_rdata` value present when done was seen.
- R8: A refused reply (code 1) ends with status 1 and no further attempt.
- R9: If `hpd` is low when `eng_done` is seen, the transaction ends with status 4 and no retry, whatever the reply code.
- R10: `busy` rises on the cycle after an accepted `start`. It falls on the cycle in which the one-cycle `stat_valid` pulse is high. A `start` that arrives while busy is ignored.
- R11: With `retry_gap` = G, each deferral that is retried delays the next attempt by exactly G cycles compared with G = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Host request strobe |
| req_cmd | input | CMD_W | Request command |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Request byte length |
| req_wdata | input | DATA_W | Request write data |
| retry_gap | input | GAP_W | Pause in cycles after a deferral |
| busy | output | 1 | Transaction in progress |
| stat_valid | output | 1 | One-cycle final status strobe |
| stat_code | output | 3 | 0 ok, 1 refused, 2 deferral limit, 3 timeout limit, 4 disconnected |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Read data |
| eng_launch | output | 1 | Attempt fire pulse |
| eng_done_ack | output | 1 | Done-flag clear request |
| eng_cmd | output | CMD_W | Command toward engine |
| eng_addr | output | ADDR_W | Address toward engine |
| eng_len | output | LEN_W | Length toward engine |
| eng_wdata | output | DATA_W | Write data toward engine |
| eng_done | input | 1 | Engine done flag |
| eng_reply | input | 2 | 0 accept, 1 refuse, 2 defer, 3 receive timeout |
| eng_rdata | input | DATA_W | Engine read data |
| hpd | input | 1 | Hot-plug detect level |

## Verification
Several properties are checked on every cycle. Launch happens only after a clean done-acknowledge. The busy and status-strobe timing is fixed. Read data appears only together with a success status. A disconnect status always follows a low hot-plug sample. The total number of attempts never exceeds both allowances plus one. Other behaviour shows only in the bench's scenarios: the exact attempt count at each allowance edge, the independence and reload of the two allowances, the watchdog length, and the exact cycle cost of the post-deferral pause.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

    localparam int unsigned DEF_TO_RETRIES    = 2;
    localparam int unsigned DEF_DEFER_RETRIES = 6;
    localparam int unsigned N_BUDGETS         = 2;
    localparam int unsigned BK_TMO            = 0;
    localparam int unsigned BK_DEF            = 1;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_NACK    = 3'd1,
        ST_DEFER   = 3'd2,
        ST_TIMEOUT = 3'd3,
        ST_NOHPD   = 3'd4
    } stat_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CLR,
        SQ_FIRE,
        SQ_WAIT,
        SQ_GAP
    } seq_e;

    typedef enum logic [2:0] {
        OC_ACK,
        OC_NACK,
        OC_DEFER,
        OC_TMO,
        OC_GONE
    } outcome_e;

    // Hot-plug loss wins over every reply code.
    function automatic outcome_e classify(input logic hpd_hi, input logic [1:0] reply);
        outcome_e r;
        if (!hpd_hi) begin
            r = OC_GONE;
        end else begin
            case (reply)
                2'd0:    r = OC_ACK;
                2'd1:    r = OC_NACK;
                2'd2:    r = OC_DEFER;
                default: r = OC_TMO;
            endcase
        end
        return r;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/aux_seq_down.sv
module aux_seq_down #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/aux_seq_budget.sv
module aux_seq_budget #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic spent
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] used;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used <= '0;
        end else if (bump && !spent) begin
            used <= used + 1'b1;
        end
    end

    assign spent = (used == LIM);
endmodule

// File: rtl/aux_seq_ctrl.sv
module aux_seq_ctrl
    import aux_seq_pkg::*;
#(
    parameter int unsigned CMD_W  = 4,
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned GAP_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CMD_W-1:0]     req_cmd,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [GAP_W-1:0]     retry_gap,
    output logic                 busy,
    output logic                 stat_valid,
    output logic [2:0]           stat_code,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 eng_launch,
    output logic                 eng_done_ack,
    output logic [CMD_W-1:0]     eng_cmd,
    output logic [ADDR_W-1:0]    eng_addr,
    output logic [LEN_W-1:0]     eng_len,
    output logic [DATA_W-1:0]    eng_wdata,
    input  logic                 eng_done,
    input  logic [1:0]           eng_reply,
    input  logic [DATA_W-1:0]    eng_rdata,
    input  logic                 hpd,
    output logic                 wd_load,
    output logic                 wd_dec,
    input  logic                 wd_zero,
    output logic                 gap_load,
    output logic [GAP_W-1:0]     gap_val,
    output logic                 gap_dec,
    input  logic                 gap_zero,
    output logic                 bud_clr,
    output logic [N_BUDGETS-1:0] bud_bump,
    input  logic [N_BUDGETS-1:0] bud_spent
);
    seq_e     st;
    outcome_e oc;
    logic     accept, seen, expire, hit_tmo, hit_def, gap_on;

    assign oc      = classify(hpd, eng_reply);
    assign accept  = (st == SQ_IDLE) && start;
    assign seen    = (st == SQ_WAIT) && eng_done;
    assign expire  = (st == SQ_WAIT) && !eng_done && wd_zero;
    assign hit_tmo = expire || (seen && oc == OC_TMO);
    assign hit_def = seen && oc == OC_DEFER;
    assign gap_on  = (retry_gap != '0);

    assign bud_clr          = accept;
    assign bud_bump[BK_TMO] = hit_tmo && !bud_spent[BK_TMO];
    assign bud_bump[BK_DEF] = hit_def && !bud_spent[BK_DEF];

    assign wd_load  = (st == SQ_FIRE);
    assign wd_dec   = (st == SQ_WAIT) && !eng_done;
    assign gap_load = bud_bump[BK_DEF] && gap_on;
    assign gap_val  = retry_gap - 1'b1;
    assign gap_dec  = (st == SQ_GAP);

    assign eng_launch   = (st == SQ_FIRE);
    assign eng_done_ack = (st == SQ_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            busy       <= 1'b0;
            stat_valid <= 1'b0;
            stat_code  <= ST_OK;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            eng_cmd    <= '0;
            eng_addr   <= '0;
            eng_len    <= '0;
            eng_wdata  <= '0;
        end else begin
            stat_valid <= 1'b0;
            rd_valid   <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        eng_cmd   <= req_cmd;
                        eng_addr  <= req_addr;
                        eng_len   <= req_len;
                        eng_wdata <= req_wdata;
                        busy      <= 1'b1;
                        st        <= SQ_CLR;
                    end
                end
                SQ_CLR: begin
                    if (!eng_done) st <= SQ_FIRE;
                end
                SQ_FIRE: begin
                    st <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (hit_tmo) begin
                        if (bud_spent[BK_TMO]) begin
                            st <= SQ_IDLE; busy <= 1'b0;
                            stat_valid <= 1'b1; stat_code <= ST_TIMEOUT;
                        end else begin
                            st <= SQ_CLR;
                        end
                    end else if (seen) begin
                        case (oc)
                            OC_ACK: begin
                                st <= SQ_IDLE; busy <= 1'b0;
                                stat_valid <= 1'b1; stat_code <= ST_OK;
                                rd_valid <= 1'b1; rd_data <= eng_rdata;
                            end
                            OC_NACK: begin
                                st <= SQ_IDLE; busy <= 1'b0;
                                stat_valid <= 1'b1; stat_code <= ST_NACK;
                            end
                            OC_DEFER: begin
                                if (bud_spent[BK_DEF]) begin
                                    st <= SQ_IDLE; busy <= 1'b0;
                                    stat_valid <= 1'b1; stat_code <= ST_DEFER;
                                end else begin
                                    st <= gap_on ? SQ_GAP : SQ_CLR;
                                end
                            end
                            default: begin
                                st <= SQ_IDLE; busy <= 1'b0;
                                stat_valid <= 1'b1; stat_code <= ST_NOHPD;
                            end
                        endcase
                    end
                end
                SQ_GAP: begin
                    if (gap_zero) st <= SQ_CLR;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
    import aux_seq_pkg::*;
#(
    parameter int unsigned CMD_W         = 4,
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned LEN_W         = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned GAP_W         = 8,
    parameter int unsigned WD_CYCLES     = 64,
    parameter int unsigned TO_RETRIES    = DEF_TO_RETRIES,
    parameter int unsigned DEFER_RETRIES = DEF_DEFER_RETRIES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [GAP_W-1:0]  retry_gap,
    output logic              busy,
    output logic              stat_valid,
    output logic [2:0]        stat_code,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              eng_launch,
    output logic              eng_done_ack,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [LEN_W-1:0]  eng_len,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic [1:0]        eng_reply,
    input  logic [DATA_W-1:0] eng_rdata,
    input  logic              hpd
);
    localparam int unsigned WD_W = width_for(WD_CYCLES);
    localparam logic [WD_W-1:0] WD_RELOAD = WD_W'(WD_CYCLES - 1);

    logic                 wd_load, wd_dec, wd_zero;
    logic                 gap_load, gap_dec, gap_zero;
    logic [GAP_W-1:0]     gap_val;
    logic                 bud_clr;
    logic [N_BUDGETS-1:0] bud_bump, bud_spent;

    aux_seq_ctrl #(
        .CMD_W(CMD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
        .DATA_W(DATA_W), .GAP_W(GAP_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .retry_gap(retry_gap),
        .busy(busy), .stat_valid(stat_valid), .stat_code(stat_code),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_launch(eng_launch), .eng_done_ack(eng_done_ack),
        .eng_cmd(eng_cmd), .eng_addr(eng_addr), .eng_len(eng_len),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_reply(eng_reply),
        .eng_rdata(eng_rdata), .hpd(hpd),
        .wd_load(wd_load), .wd_dec(wd_dec), .wd_zero(wd_zero),
        .gap_load(gap_load), .gap_val(gap_val), .gap_dec(gap_dec),
        .gap_zero(gap_zero),
        .bud_clr(bud_clr), .bud_bump(bud_bump), .bud_spent(bud_spent)
    );

    aux_seq_down #(.W(WD_W)) u_wdog (
        .clk(clk), .rst(rst), .load(wd_load), .load_val(WD_RELOAD),
        .dec(wd_dec), .zero(wd_zero)
    );

    aux_seq_down #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val),
        .dec(gap_dec), .zero(gap_zero)
    );

    for (genvar k = 0; k < N_BUDGETS; k++) begin : g_budget
        localparam int unsigned LIM = (k == BK_TMO) ? TO_RETRIES : DEFER_RETRIES;
        aux_seq_budget #(.LIMIT(LIM)) u_bud (
            .clk(clk), .rst(rst), .clr(bud_clr),
            .bump(bud_bump[k]), .spent(bud_spent[k])
        );
    end
endmodule

// File: rtl/aux_retry_seq_chk.sv
module aux_retry_seq_chk #(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned TO_RETRIES    = 2,
    parameter int unsigned DEFER_RETRIES = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              stat_valid,
    input logic [2:0]        stat_code,
    input logic              rd_valid,
    input logic              eng_launch,
    input logic              eng_done_ack,
    input logic              eng_done,
    input logic [ADDR_W-1:0] eng_addr,
    input logic              hpd
);
    localparam int unsigned MAX_TRIES = TO_RETRIES + DEFER_RETRIES + 1;
    int unsigned tries;

    always_ff @(posedge clk) begin
        if (rst || (!busy && start)) tries <= 0;
        else if (eng_launch)         tries <= tries + 1;
    end

    // R2
    launch_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        eng_launch |-> $past(eng_done_ack && !eng_done));

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    // R10
    stat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> !busy);

    // R7
    rd_with_ok_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (stat_valid && stat_code == 3'd0));

    // R9
    gone_hpd_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_valid && stat_code == 3'd4) |-> $past(!hpd));

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(eng_addr));

    // R6
    try_cap_chk: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (tries <= MAX_TRIES));
endmodule

bind aux_retry_seq aux_retry_seq_chk #(
    .ADDR_W(ADDR_W), .TO_RETRIES(TO_RETRIES), .DEFER_RETRIES(DEFER_RETRIES)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .stat_valid(stat_valid), .stat_code(stat_code), .rd_valid(rd_valid),
    .eng_launch(eng_launch), .eng_done_ack(eng_done_ack),
    .eng_done(eng_done), .eng_addr(eng_addr), .hpd(hpd)
);

// File: tb/aux_retry_seq_bench.sv
`timescale 1ns/1ps
module aux_retry_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  req_cmd = 4'h9;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_len = 4'h3;
    logic [31:0] req_wdata = 32'h1234_5678;
    logic [7:0]  retry_gap = '0;
    logic        busy, stat_valid, rd_valid, eng_launch, eng_done_ack;
    logic [2:0]  stat_code;
    logic [31:0] rd_data, eng_wdata;
    logic [3:0]  eng_cmd, eng_len;
    logic [19:0] eng_addr;
    logic        eng_done = 1'b0;
    logic [1:0]  eng_reply = '0;
    logic [31:0] eng_rdata = '0;
    logic        hpd = 1'b1;

    always #2 clk = ~clk;

    aux_retry_seq u_aux_retry_seq (
        .clk(clk), .rst(rst), .start(start), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .retry_gap(retry_gap), .busy(busy), .stat_valid(stat_valid),
        .stat_code(stat_code), .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_launch(eng_launch), .eng_done_ack(eng_done_ack),
        .eng_cmd(eng_cmd), .eng_addr(eng_addr), .eng_len(eng_len),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_reply(eng_reply),
        .eng_rdata(eng_rdata), .hpd(hpd)
    );

    int nchk = 0, nbad = 0, cycles = 0;
    // Reply script: 0 accept, 1 refuse, 2 defer, 3 receive timeout, 4 never answer
    int script[$];
    int launches = 0, total_launches = 0, bad_launch = 0, bad_field = 0;
    int lat = 0, pend = 0;
    bit armed = 0;
    logic [31:0] ack_data = '0;
    logic [19:0] exp_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            nbad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Behavioural engine: answers each launch three cycles later, clears on ack.
    always @(posedge clk) begin
        if (eng_done && eng_done_ack) eng_done <= 1'b0;
        if (eng_launch) begin
            int code;
            code = (script.size() > 0) ? script.pop_front() : 0;
            launches++;
            total_launches++;
            if (eng_done) bad_launch++;
            if (eng_addr != exp_addr || eng_cmd != req_cmd || eng_len != req_len
                || eng_wdata != req_wdata) bad_field++;
            pend  <= code;
            lat   <= 2;
            armed <= (code != 4);
        end else if (armed) begin
            if (lat == 0) begin
                eng_done  <= 1'b1;
                eng_reply <= 2'(pend);
                eng_rdata <= 32'hC0DE_0000 | 32'(total_launches);
                if (pend == 0) ack_data = 32'hC0DE_0000 | 32'(total_launches);
                armed <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    task automatic run_txn(input string req, input int gap, input int exp_st,
                           input int exp_n, input bit poke, output int dur);
        int n;
        launches  = 0;
        bad_field = 0;
        retry_gap = 8'(gap);
        exp_addr  = exp_addr + 20'h111;
        req_addr  = exp_addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!stat_valid && n < 5000) begin
            chk(busy == 1'b1, "R10 busy held", int'(busy), 1);
            if (poke && n == 5) begin
                start = 1'b1;
                req_addr = 20'hFFFFF;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start    = 1'b0;
        req_addr = exp_addr;
        dur = n;
        chk(stat_valid == 1'b1, {req, " status strobe"}, int'(stat_valid), 1);
        chk(int'(stat_code) == exp_st, {req, " status"}, int'(stat_code), exp_st);
        chk(launches == exp_n, {req, " attempts"}, launches, exp_n);
        chk(busy == 1'b0, "R10 busy low with status", int'(busy), 0);
        chk(rd_valid == (exp_st == 0), "R7 read strobe", int'(rd_valid), int'(exp_st == 0));
        if (exp_st == 0)
            chk(rd_data == ack_data, "R7 read data", int'(rd_data), int'(ack_data));
        chk(bad_field == 0, "R1 request fields at launch", bad_field, 0);
        @(negedge clk);
        chk(stat_valid == 1'b0, "R10 status one cycle", int'(stat_valid), 0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && launches == exp_n, "R10 no trailing start",
            launches, exp_n);
    endtask

    initial begin
        int d, d0, d1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && stat_valid == 0, "reset outputs idle", int'(busy), 0);
        chk(eng_launch == 0 && eng_done_ack == 0, "reset engine side idle",
            int'(eng_launch), 0);

        script = '{0};             run_txn("R7 accept", 0, 0, 1, 0, d);
        script = '{1};             run_txn("R8 refuse", 0, 1, 1, 0, d);
        script = '{2, 2, 2, 0};    run_txn("R5 three defers", 0, 0, 4, 0, d0);
        script = '{2, 2, 2, 0};    run_txn("R11 gap run", 10, 0, 4, 0, d1);
        chk(d1 - d0 == 30, "R11 pause cost", d1 - d0, 30);
        script = '{2, 2, 2, 2, 2, 2, 0};    run_txn("R5 six defers", 0, 0, 7, 0, d);
        script = '{2, 2, 2, 2, 2, 2, 2, 0}; run_txn("R5 defer limit", 3, 2, 7, 0, d);
        script = '{3, 3, 0};       run_txn("R4 two timeouts", 0, 0, 3, 0, d);
        script = '{3, 3, 3, 0};    run_txn("R4 timeout limit", 0, 3, 3, 0, d);
        script = '{4, 4, 4};       run_txn("R3 watchdog limit", 0, 3, 3, 0, d);
        chk(d >= 3 * 64, "R3 watchdog length", d, 3 * 64);
        script = '{4, 0};          run_txn("R3 watchdog then accept", 0, 0, 2, 0, d);
        chk(d >= 64 && d < 128, "R3 single watchdog span", d, 64);
        script = '{3, 2, 3, 2, 2, 2, 2, 2, 0};
        run_txn("R6 mixed allowances", 0, 0, 9, 0, d);
        script = '{3, 3, 0};       run_txn("R6 allowance reloaded", 0, 0, 3, 0, d);
        hpd = 1'b0;
        script = '{2};             run_txn("R9 disconnect", 0, 4, 1, 0, d);
        script = '{0};             run_txn("R9 disconnect on accept", 0, 4, 1, 0, d);
        hpd = 1'b1;
        script = '{2, 2, 0};       run_txn("R10 start while busy", 2, 0, 3, 1, d);
        chk(bad_launch == 0, "R2 launch with done low", bad_launch, 0);
        finish_run();
    end
endmodule